// File: doc/BRIEF.md
# Sequential-Line Instruction Prefetcher with One-Entry Stream Buffer

This block sits between an instruction L1 cache and the next level of the memory hierarchy. When the L1 misses on a line that is not already held on the side, the block fetches that line from the next level and delivers it to the L1. It also fetches the line that follows it in sequence and keeps that second line in a single-entry stream buffer, not in the L1.

A later L1 miss can match the buffered line. In that case the line moves into the L1 without any new access to the next level, and the block then prefetches the line after it, so a straight run of instruction fetches keeps the buffer one line ahead. A miss that matches the buffer while its prefetch is still in flight waits for that response instead of asking for the line a second time.

A miss that does not match the buffer retags the buffer to the new sequence. Any prefetch response still in flight for the old tag is thrown away when it arrives. The L1 array is modelled as a sink for refill beats, and line addresses wrap around modulo the address width.

Top module: `istream_prefetch`

## Requirements
- R1: After reset `miss_ready` is 1, the stream buffer is empty (`sb_valid`=0, `sb_pending`=0), and neither `nl_req_valid` nor `refill_valid` is asserted.
- R2: An accepted miss to line i that does not match the buffer presents a demand request for line i (`nl_req_pf`=0) on the cycle after acceptance. A prefetch request for line i+1 (`nl_req_pf`=1) follows it. The demand always goes out before the prefetch.
- R3: A demand response produces exactly one refill beat, with `refill_line` equal to the missed line and `refill_data` equal to the response data. A prefetched line is never refilled unless a later miss names it.
- R4: From the cycle after a non-matching miss to line i is accepted, the buffer reports line i+1 with `sb_valid`=1 and `sb_pending`=1. `sb_pending` returns to 0 once the prefetch response has been taken.
- R5: A miss that matches a filled buffer entry (`sb_pending`=0) puts the buffered data on the refill port one cycle after acceptance, and issues no demand request.
- R6: After the buffered line i is moved into the L1, the buffer is retagged to i+1 with `sb_pending`=1, and exactly one prefetch request for i+1 is issued.
- R7: A miss that matches a pending entry issues no second request. It refills that line with the prefetch response data in the cycle after the response is taken, and then prefetches the following line.
- R8: A non-matching miss while a prefetch is outstanding discards that late response. The new prefetch is issued only after the old one returns, so at most one prefetch is ever outstanding. A later hit on the new line returns the new line's data.
- R9: Line addresses wrap: a miss to the all-ones line tags the buffer with line 0, and a later miss to line 0 is served from the buffer.
- R10: `miss_ready` is 0 while a demand miss or a wait on a pending entry is in progress. A hit on a filled entry leaves `miss_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | L1 miss request |
| miss_line | input | AW | Line address of the miss |
| miss_ready | output | 1 | Block can accept a miss this cycle |
| refill_valid | output | 1 | One-cycle refill beat to the L1 |
| refill_line | output | AW | Line address being refilled |
| refill_data | output | DW | Refill line data |
| nl_req_valid | output | 1 | Next-level request valid |
| nl_req_ready | input | 1 | Next level accepts the request |
| nl_req_line | output | AW | Requested line address |
| nl_req_pf | output | 1 | 1 = prefetch, 0 = demand |
| nl_rsp_valid | input | 1 | Next-level response valid |
| nl_rsp_pf | input | 1 | 1 = response to the prefetch, 0 = to the demand |
| nl_rsp_data | input | DW | Response line data |
| sb_valid | output | 1 | Stream buffer holds a tag |
| sb_pending | output | 1 | Stream buffer data still awaited |
| sb_line | output | AW | Stream buffer line tag |

## Verification
A hit on a filled buffer entry must appear on the refill port on the cycle right after the acceptance edge. A demand request must appear on the cycle after a non-matching miss, with the prefetch request one cycle after that. A refill for a demand or a pending hit appears on the same edge at which the response is taken. The bench drives inputs and samples outputs at falling clock edges, logging every request and refill beat there. Each check then compares those logs at a fixed point: right after acceptance for buffer hits, or after the block is ready again for misses that go to the next level. The next-level model gives demand and prefetch separate latencies, so that responses arrive both in request order and out of it.

// File: rtl/spf_pkg.sv
package spf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DEMAND = 2'd1,
        ST_PFWAIT = 2'd2
    } ctl_state_e;

    typedef enum logic {
        SRC_DEMAND   = 1'b0,
        SRC_PREFETCH = 1'b1
    } req_src_e;

endpackage

// File: rtl/spf_stream_buf.sv
module spf_stream_buf #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_en,
    input  logic [AW-1:0] alloc_line,
    input  logic          fill_en,
    input  logic [DW-1:0] fill_data,
    input  logic [AW-1:0] probe_line,
    output logic          probe_hit,
    output logic          ent_valid,
    output logic          ent_pending,
    output logic [AW-1:0] ent_line,
    output logic [DW-1:0] ent_data
);
    typedef struct packed {
        logic          valid;
        logic          pending;
        logic [AW-1:0] line;
        logic [DW-1:0] data;
    } sb_entry_t;

    sb_entry_t ent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else if (alloc_en) begin
            ent_q.valid   <= 1'b1;
            ent_q.pending <= 1'b1;
            ent_q.line    <= alloc_line;
        end else if (fill_en) begin
            ent_q.pending <= 1'b0;
            ent_q.data    <= fill_data;
        end
    end

    assign probe_hit   = ent_q.valid && (ent_q.line == probe_line);
    assign ent_valid   = ent_q.valid;
    assign ent_pending = ent_q.pending;
    assign ent_line    = ent_q.line;
    assign ent_data    = ent_q.data;
endmodule

// File: rtl/spf_req_arb.sv
module spf_req_arb
    import spf_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          dem_want,
    input  logic [AW-1:0] dem_line,
    input  logic          pf_want,
    input  logic [AW-1:0] pf_line,
    input  logic          req_ready,
    output logic          req_valid,
    output logic [AW-1:0] req_line,
    output logic          req_src,
    output logic          dem_fire,
    output logic          pf_fire
);
    req_src_e src;

    always_comb begin
        if (dem_want) begin
            src      = SRC_DEMAND;
            req_line = dem_line;
        end else begin
            src      = SRC_PREFETCH;
            req_line = pf_line;
        end
    end

    assign req_valid = dem_want || pf_want;
    assign req_src   = src;
    assign dem_fire  = dem_want && req_ready;
    assign pf_fire   = !dem_want && pf_want && req_ready;
endmodule

// File: rtl/spf_refill_reg.sv
module spf_refill_reg #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] line_in,
    input  logic [DW-1:0] data_in,
    output logic          out_valid,
    output logic [AW-1:0] out_line,
    output logic [DW-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_line  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= load;
            if (load) begin
                out_line <= line_in;
                out_data <= data_in;
            end
        end
    end
endmodule

// File: rtl/istream_prefetch.sv
module istream_prefetch
    import spf_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          miss_valid,
    input  logic [AW-1:0] miss_line,
    output logic          miss_ready,
    output logic          refill_valid,
    output logic [AW-1:0] refill_line,
    output logic [DW-1:0] refill_data,
    output logic          nl_req_valid,
    input  logic          nl_req_ready,
    output logic [AW-1:0] nl_req_line,
    output logic          nl_req_pf,
    input  logic          nl_rsp_valid,
    input  logic          nl_rsp_pf,
    input  logic [DW-1:0] nl_rsp_data,
    output logic          sb_valid,
    output logic          sb_pending,
    output logic [AW-1:0] sb_line
);
    localparam logic [AW-1:0] LINE_STEP = AW'(1);

    ctl_state_e    state_q, state_d;
    logic          dem_send_q, pf_send_q, pf_out_q, pf_drop_q;
    logic [AW-1:0] dem_line_q;

    logic          ent_valid, ent_pending, probe_hit;
    logic [AW-1:0] ent_line;
    logic [DW-1:0] ent_data;

    logic          alloc_en, flush, dem_set, rf_load;
    logic [AW-1:0] alloc_line, rf_line;
    logic [DW-1:0] rf_data;
    logic          dem_fire, pf_fire, pf_want, req_src;

    logic miss_fire, rsp_dem, rsp_pf, rsp_pf_good;

    assign miss_fire   = miss_valid && (state_q == ST_IDLE);
    assign rsp_dem     = nl_rsp_valid && (nl_rsp_pf == SRC_DEMAND);
    assign rsp_pf      = nl_rsp_valid && (nl_rsp_pf == SRC_PREFETCH);
    assign rsp_pf_good = rsp_pf && !pf_drop_q;
    assign pf_want     = pf_send_q && !pf_out_q;

    spf_stream_buf #(.AW(AW), .DW(DW)) u_sbuf (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (alloc_en),
        .alloc_line (alloc_line),
        .fill_en    (rsp_pf_good),
        .fill_data  (nl_rsp_data),
        .probe_line (miss_line),
        .probe_hit  (probe_hit),
        .ent_valid  (ent_valid),
        .ent_pending(ent_pending),
        .ent_line   (ent_line),
        .ent_data   (ent_data)
    );

    spf_req_arb #(.AW(AW)) u_arb (
        .dem_want (dem_send_q),
        .dem_line (dem_line_q),
        .pf_want  (pf_want),
        .pf_line  (ent_line),
        .req_ready(nl_req_ready),
        .req_valid(nl_req_valid),
        .req_line (nl_req_line),
        .req_src  (req_src),
        .dem_fire (dem_fire),
        .pf_fire  (pf_fire)
    );

    spf_refill_reg #(.AW(AW), .DW(DW)) u_refill (
        .clk      (clk),
        .rst      (rst),
        .load     (rf_load),
        .line_in  (rf_line),
        .data_in  (rf_data),
        .out_valid(refill_valid),
        .out_line (refill_line),
        .out_data (refill_data)
    );

    // Control: decides per state whether a miss goes to the buffer or the next level
    always_comb begin
        state_d    = state_q;
        alloc_en   = 1'b0;
        alloc_line = '0;
        flush      = 1'b0;
        dem_set    = 1'b0;
        rf_load    = 1'b0;
        rf_line    = '0;
        rf_data    = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (miss_fire) begin
                    if (probe_hit && !ent_pending) begin
                        rf_load    = 1'b1;
                        rf_line    = miss_line;
                        rf_data    = ent_data;
                        alloc_en   = 1'b1;
                        alloc_line = miss_line + LINE_STEP;
                    end else if (probe_hit) begin
                        state_d = ST_PFWAIT;
                    end else begin
                        alloc_en   = 1'b1;
                        alloc_line = miss_line + LINE_STEP;
                        flush      = 1'b1;
                        dem_set    = 1'b1;
                        state_d    = ST_DEMAND;
                    end
                end
            end
            ST_DEMAND: begin
                if (rsp_dem) begin
                    rf_load = 1'b1;
                    rf_line = dem_line_q;
                    rf_data = nl_rsp_data;
                    state_d = ST_IDLE;
                end
            end
            ST_PFWAIT: begin
                if (ent_valid && !ent_pending) begin
                    rf_load    = 1'b1;
                    rf_line    = ent_line;
                    rf_data    = ent_data;
                    alloc_en   = 1'b1;
                    alloc_line = ent_line + LINE_STEP;
                    state_d    = ST_IDLE;
                end else if (rsp_pf_good) begin
                    rf_load    = 1'b1;
                    rf_line    = ent_line;
                    rf_data    = nl_rsp_data;
                    alloc_en   = 1'b1;
                    alloc_line = ent_line + LINE_STEP;
                    state_d    = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            dem_send_q <= 1'b0;
            dem_line_q <= '0;
            pf_send_q  <= 1'b0;
            pf_out_q   <= 1'b0;
            pf_drop_q  <= 1'b0;
        end else begin
            state_q <= state_d;

            if (dem_set) begin
                dem_send_q <= 1'b1;
                dem_line_q <= miss_line;
            end else if (dem_fire) begin
                dem_send_q <= 1'b0;
            end

            if (alloc_en) begin
                pf_send_q <= 1'b1;
            end else if (pf_fire) begin
                pf_send_q <= 1'b0;
            end

            if (pf_fire) begin
                pf_out_q <= 1'b1;
            end else if (rsp_pf) begin
                pf_out_q <= 1'b0;
            end

            if (flush) begin
                pf_drop_q <= (pf_out_q && !rsp_pf) || pf_fire;
            end else if (rsp_pf) begin
                pf_drop_q <= 1'b0;
            end
        end
    end

    assign miss_ready = (state_q == ST_IDLE);
    assign nl_req_pf  = req_src;
    assign sb_valid   = ent_valid;
    assign sb_pending = ent_pending;
    assign sb_line    = ent_line;
endmodule

// File: rtl/istream_prefetch_chk.sv
module istream_prefetch_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          miss_valid,
    input logic [AW-1:0] miss_line,
    input logic          miss_ready,
    input logic          refill_valid,
    input logic [AW-1:0] refill_line,
    input logic          nl_req_valid,
    input logic          nl_req_ready,
    input logic [AW-1:0] nl_req_line,
    input logic          nl_req_pf,
    input logic          nl_rsp_valid,
    input logic          nl_rsp_pf,
    input logic          sb_valid,
    input logic          sb_pending,
    input logic [AW-1:0] sb_line
);
    logic [1:0] pf_inflight;
    logic       acc, acc_hit_full, acc_miss;

    assign acc          = miss_valid && miss_ready;
    assign acc_hit_full = acc && sb_valid && !sb_pending && (sb_line == miss_line);
    assign acc_miss     = acc && !(sb_valid && (sb_line == miss_line));

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_inflight <= '0;
        end else begin
            pf_inflight <= pf_inflight
                         + 2'((nl_req_valid && nl_req_ready && nl_req_pf) ? 1 : 0)
                         - 2'((nl_rsp_valid && nl_rsp_pf) ? 1 : 0);
        end
    end

    AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (rst)
        acc_miss |=> (nl_req_valid && !nl_req_pf && nl_req_line == $past(miss_line))); // R2

    AST_HIT_REFILL: assert property (@(posedge clk) disable iff (rst)
        acc_hit_full |=> (refill_valid && refill_line == $past(miss_line))); // R5

    AST_HIT_CHAIN: assert property (@(posedge clk) disable iff (rst)
        acc_hit_full |=> (sb_valid && sb_pending && sb_line == AW'($past(miss_line) + AW'(1)))); // R6

    AST_MISS_TAG: assert property (@(posedge clk) disable iff (rst)
        acc_miss |=> (sb_valid && sb_pending && sb_line == AW'($past(miss_line) + AW'(1)))); // R4

    AST_ONE_PREFETCH: assert property (@(posedge clk) disable iff (rst)
        (nl_req_valid && nl_req_ready && nl_req_pf) |-> (pf_inflight == 2'd0)); // R8

    AST_BUSY: assert property (@(posedge clk) disable iff (rst)
        (acc && !acc_hit_full) |=> !miss_ready); // R10
endmodule

bind istream_prefetch istream_prefetch_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .miss_valid  (miss_valid),
    .miss_line   (miss_line),
    .miss_ready  (miss_ready),
    .refill_valid(refill_valid),
    .refill_line (refill_line),
    .nl_req_valid(nl_req_valid),
    .nl_req_ready(nl_req_ready),
    .nl_req_line (nl_req_line),
    .nl_req_pf   (nl_req_pf),
    .nl_rsp_valid(nl_rsp_valid),
    .nl_rsp_pf   (nl_rsp_pf),
    .sb_valid    (sb_valid),
    .sb_pending  (sb_pending),
    .sb_line     (sb_line)
);

// File: tb/sim_istream_prefetch.sv
module sim_istream_prefetch;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_line = '0;
    logic          miss_ready;
    logic          refill_valid;
    logic [AW-1:0] refill_line;
    logic [DW-1:0] refill_data;
    logic          nl_req_valid;
    logic          nl_req_ready = 1'b1;
    logic [AW-1:0] nl_req_line;
    logic          nl_req_pf;
    logic          nl_rsp_valid = 1'b0;
    logic          nl_rsp_pf = 1'b0;
    logic [DW-1:0] nl_rsp_data = '0;
    logic          sb_valid, sb_pending;
    logic [AW-1:0] sb_line;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    istream_prefetch #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_line(miss_line), .miss_ready(miss_ready),
        .refill_valid(refill_valid), .refill_line(refill_line), .refill_data(refill_data),
        .nl_req_valid(nl_req_valid), .nl_req_ready(nl_req_ready),
        .nl_req_line(nl_req_line), .nl_req_pf(nl_req_pf),
        .nl_rsp_valid(nl_rsp_valid), .nl_rsp_pf(nl_rsp_pf), .nl_rsp_data(nl_rsp_data),
        .sb_valid(sb_valid), .sb_pending(sb_pending), .sb_line(sb_line)
    );

    function automatic logic [DW-1:0] line_data(input logic [AW-1:0] l);
        return {l ^ 16'h5A3C, l};
    endfunction

    // Logs of requests and refill beats, plus a next-level model
    logic [AW-1:0] req_line_log [0:255];
    bit            req_pf_log   [0:255];
    int            req_n = 0;
    logic [AW-1:0] ref_line_log [0:63];
    logic [DW-1:0] ref_data_log [0:63];
    int            ref_n = 0;

    int dem_lat = 2, pf_lat = 2;
    bit dem_busy = 0, pf_busy = 0;
    int dem_wait = 0, pf_wait = 0;
    logic [AW-1:0] dem_ln = '0, pf_ln = '0;

    always @(negedge clk) begin
        bit driven;
        nl_rsp_valid = 1'b0;
        driven = 0;
        if (!rst) begin
            if (refill_valid && ref_n < 64) begin
                ref_line_log[ref_n] = refill_line;
                ref_data_log[ref_n] = refill_data;
                ref_n++;
            end
            if (dem_busy) begin
                if (dem_wait == 0) begin
                    nl_rsp_valid = 1'b1; nl_rsp_pf = 1'b0; nl_rsp_data = line_data(dem_ln);
                    dem_busy = 0; driven = 1;
                end else dem_wait--;
            end
            if (pf_busy) begin
                if (pf_wait == 0 && !driven) begin
                    nl_rsp_valid = 1'b1; nl_rsp_pf = 1'b1; nl_rsp_data = line_data(pf_ln);
                    pf_busy = 0;
                end else if (pf_wait > 0) pf_wait--;
            end
            if (nl_req_valid && nl_req_ready) begin
                if (req_n < 256) begin
                    req_line_log[req_n] = nl_req_line;
                    req_pf_log[req_n]   = nl_req_pf;
                    req_n++;
                end
                if (nl_req_pf) begin pf_busy = 1; pf_wait = pf_lat; pf_ln = nl_req_line; end
                else begin dem_busy = 1; dem_wait = dem_lat; dem_ln = nl_req_line; end
            end
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_ready();
        for (int g = 0; g < 200 && !miss_ready; g++) step(1);
    endtask

    task automatic issue_miss(input logic [AW-1:0] l);
        wait_ready();
        miss_valid = 1'b1;
        miss_line  = l;
        step(1);
        miss_valid = 1'b0;
    endtask

    task automatic t_reset();
        check(miss_ready == 1'b1, "R1 miss_ready", miss_ready, 1);
        check(sb_valid == 1'b0 && sb_pending == 1'b0, "R1 sb empty", {sb_valid, sb_pending}, 0);
        check(nl_req_valid == 1'b0, "R1 no request", nl_req_valid, 0);
        check(refill_valid == 1'b0, "R1 no refill", refill_valid, 0);
    endtask

    task automatic t_cold();
        int q0, r0;
        dem_lat = 2; pf_lat = 3;
        q0 = req_n; r0 = ref_n;
        issue_miss(16'h0100);
        check(sb_valid && sb_pending && sb_line == 16'h0101, "R4 tag pending", sb_line, 16'h0101);
        check(miss_ready == 1'b0, "R10 busy on demand", miss_ready, 0);
        wait_ready(); step(8);
        check(req_n == q0 + 2, "R2 request count", req_n - q0, 2);
        check(req_pf_log[q0] == 0 && req_line_log[q0] == 16'h0100, "R2 demand first", req_line_log[q0], 16'h0100);
        check(req_pf_log[q0+1] == 1 && req_line_log[q0+1] == 16'h0101, "R2 prefetch next", req_line_log[q0+1], 16'h0101);
        check(ref_n == r0 + 1, "R3 single refill", ref_n - r0, 1);
        check(ref_line_log[r0] == 16'h0100 && ref_data_log[r0] == line_data(16'h0100), "R3 refill data",
              ref_data_log[r0], line_data(16'h0100));
        check(sb_valid && !sb_pending && sb_line == 16'h0101, "R4 filled", {sb_pending, sb_line}, 16'h0101);
    endtask

    task automatic t_hit();
        int q0, r0;
        q0 = req_n; r0 = ref_n;
        issue_miss(16'h0101);
        check(ref_n == r0 + 1, "R5 refill next cycle", ref_n - r0, 1);
        check(ref_line_log[r0] == 16'h0101 && ref_data_log[r0] == line_data(16'h0101), "R5 buffered data",
              ref_data_log[r0], line_data(16'h0101));
        check(miss_ready == 1'b1, "R10 hit no stall", miss_ready, 1);
        check(sb_pending && sb_line == 16'h0102, "R6 retag", sb_line, 16'h0102);
        step(8);
        check(req_n == q0 + 1 && req_pf_log[q0] == 1 && req_line_log[q0] == 16'h0102, "R6 chained prefetch",
              req_line_log[q0], 16'h0102);
        check(!sb_pending, "R6 chained fill", sb_pending, 0);
    endtask

    task automatic t_pending();
        int q0, r0, g;
        dem_lat = 1; pf_lat = 12;
        issue_miss(16'h0200);
        wait_ready();
        q0 = req_n; r0 = ref_n;
        issue_miss(16'h0201);
        check(miss_ready == 1'b0, "R10 busy on pending", miss_ready, 0);
        step(4);
        check(req_n == q0, "R7 no duplicate", req_n - q0, 0);
        check(ref_n == r0, "R7 waits", ref_n - r0, 0);
        for (g = 0; g < 40 && ref_n == r0; g++) step(1);
        check(ref_n == r0 + 1 && ref_line_log[r0] == 16'h0201 && ref_data_log[r0] == line_data(16'h0201),
              "R7 refill on response", ref_data_log[r0], line_data(16'h0201));
        step(20);
        check(req_n == q0 + 1 && req_line_log[q0] == 16'h0202 && req_pf_log[q0] == 1, "R7 next prefetch",
              req_line_log[q0], 16'h0202);
    endtask

    task automatic t_flush();
        int q0, r0;
        dem_lat = 1; pf_lat = 12;
        wait_ready(); step(20);
        issue_miss(16'h0400);
        wait_ready();
        q0 = req_n;
        issue_miss(16'h0500);
        check(sb_pending && sb_line == 16'h0501, "R8 retag on miss", sb_line, 16'h0501);
        wait_ready();
        check(req_n == q0 + 1 && req_pf_log[q0] == 0 && req_line_log[q0] == 16'h0500, "R8 demand only",
              req_n - q0, 1);
        step(25);
        check(req_n == q0 + 2 && req_pf_log[q0+1] == 1 && req_line_log[q0+1] == 16'h0501, "R8 prefetch after stale",
              req_line_log[q0+1], 16'h0501);
        check(!sb_pending, "R8 filled", sb_pending, 0);
        r0 = ref_n;
        issue_miss(16'h0501);
        check(ref_n == r0 + 1 && ref_data_log[r0] == line_data(16'h0501), "R8 stale discarded",
              ref_data_log[r0], line_data(16'h0501));
        step(20);
    endtask

    task automatic t_reorder();
        int r0;
        dem_lat = 6; pf_lat = 0;
        wait_ready(); step(20);
        r0 = ref_n;
        issue_miss(16'h0700);
        wait_ready(); step(2);
        check(ref_n == r0 + 1 && ref_line_log[r0] == 16'h0700 && ref_data_log[r0] == line_data(16'h0700),
              "R3 demand after early prefetch", ref_data_log[r0], line_data(16'h0700));
        check(sb_valid && !sb_pending && sb_line == 16'h0701, "R4 early fill", sb_line, 16'h0701);
    endtask

    task automatic t_wrap();
        int r0, q0;
        dem_lat = 2; pf_lat = 2;
        wait_ready(); step(10);
        issue_miss(16'hFFFF);
        check(sb_line == 16'h0000 && sb_valid, "R9 wrap tag", sb_line, 0);
        wait_ready(); step(8);
        r0 = ref_n; q0 = req_n;
        issue_miss(16'h0000);
        check(ref_n == r0 + 1 && ref_line_log[r0] == 16'h0000 && ref_data_log[r0] == line_data(16'h0000),
              "R9 wrap hit", ref_data_log[r0], line_data(16'h0000));
        step(8);
        check(req_n == q0 + 1 && req_line_log[q0] == 16'h0001, "R9 wrap chain", req_line_log[q0], 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_cold();
        t_hit();
        t_pending();
        t_flush();
        t_reorder();
        t_wrap();
        step(5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule